// File: doc/BRIEF.md
# Per-core interrupt hierarchy summary

This block sits between the interrupt source groups and the processor cores of a four-core cluster. Each of 32 groups hands it twelve masked request vectors of 32 bits. There is one vector for each pairing of core and class, and it holds the sources of that group that are pending and steered to that class on that core. For every core the block reduces these vectors into three 32-bit summary words, one each for non-critical, critical and machine check. Bit g of a word is set while group g has at least one such source. Steering, including sending one source to all cores, is resolved upstream in the groups. A source that is sent to every core therefore appears in all four cores' vectors, and so in all four summary words of its class.

From the summary words the block drives three registered interrupt lines per core. It also drives a registered 2-bit code per core that names the most urgent pending class. A handler selects a core and a class on the read port and gets that summary word back on the next cycle. It then knows which group to interrogate. The summary words have no storage of their own. They follow the group vectors, so a bit drops when the sources under it are cleared.

Top module: `irq_hier_sum`

## Requirements
- R1: Vector (group g, core c, class k) occupies `mirq_i[((g*4 + c)*3 + k)*32 +: 32]`, with k = 0 for non-critical, 1 for critical and 2 for machine check. Summary bit g of (c, k) is the OR of that vector. When `rd_core_i` = c and `rd_cls_i` = k are presented before a rising edge, `rd_data_o` shows that word after the edge.
- R2: The summary bit position equals the group number across the whole range. A single source at bit 31 of group 31 reads back as 32'h8000_0000, and a single source at bit 0 of group 0 reads back as 32'h0000_0001.
- R3: A source that is present in the vectors of all four cores for one class sets that group's bit in all four cores' summary words of that class, and raises that class's line on every core.
- R4: `irq_ext_o[c]`, `irq_crit_o[c]` and `irq_mc_o[c]` are each the OR of core c's summary word of that class, and they are registered one cycle after the vectors.
- R5: `top_cls_o[2*c +: 2]` is registered one cycle after the vectors. It is 2'b11 when core c has machine check pending. Otherwise it is 2'b10 when critical is pending, otherwise 2'b01 when non-critical is pending, and otherwise 2'b00.
- R6: When the vectors under a summary bit all drop to zero, that bit, the read data showing it and the line it drove fall one cycle later, with no extra clear action.
- R7: `rd_cls_i` = 3 returns all zeros on `rd_data_o`, whatever is pending.
- R8: While `rst_n` is low, all lines, codes and the read data are zero.
- R9: A vector for core c changes no line, code or summary word of any other core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted in step with clk |
| mirq_i | input | 12288 | Masked request vectors of all groups, cores and classes (layout in R1) |
| rd_core_i | input | 2 | Core whose summary word is read |
| rd_cls_i | input | 2 | Class to read: 0 non-critical, 1 critical, 2 machine check, 3 none |
| rd_data_o | output | 32 | Selected summary word, one bit per group, registered |
| irq_ext_o | output | 4 | Non-critical interrupt line per core |
| irq_crit_o | output | 4 | Critical interrupt line per core |
| irq_mc_o | output | 4 | Machine check interrupt line per core |
| top_cls_o | output | 8 | Most urgent pending class per core, 2 bits per core (R5) |

## Verification
Every output of this block lags its cause by exactly one rising edge. That holds for a new or cleared request vector and for a change of read select: the summary reduction is combinational and there is a single register stage in front of each output. The bench changes inputs just after a rising edge. Its reference model captures the expected lines, codes and read word from the inputs present at each rising edge. It compares them at the following falling edge, when the registered outputs have settled and no input is moving. Directed checks for the boundary groups, sources sent to all cores, priority steps, clearing, the unused class code and core isolation wait one edge before sampling.

// File: rtl/ihs_pkg.sv
package ihs_pkg;

  localparam int NUM_CLS  = 3;
  localparam int CLS_EXT  = 0;
  localparam int CLS_CRIT = 1;
  localparam int CLS_MC   = 2;

  typedef enum logic [1:0] {
    TOP_NONE = 2'b00,
    TOP_EXT  = 2'b01,
    TOP_CRIT = 2'b10,
    TOP_MC   = 2'b11
  } top_cls_e;

endpackage

// File: rtl/ihs_hier_build.sv
module ihs_hier_build
  import ihs_pkg::*;
#(
  parameter int NUM_GRP  = 32,
  parameter int NUM_CORE = 4,
  parameter int GRP_SRC  = 32,
  localparam int MW = NUM_GRP * NUM_CORE * NUM_CLS * GRP_SRC,
  localparam int HW = NUM_CORE * NUM_CLS * NUM_GRP
) (
  input  logic [MW-1:0] mirq_i,
  output logic [HW-1:0] hier_o
);

  // Summary word (core c, class k) sits at hier_o[(c*NUM_CLS+k)*NUM_GRP +: NUM_GRP]
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
        localparam int SRC_BASE = ((g * NUM_CORE + c) * NUM_CLS + k) * GRP_SRC;
        localparam int HIER_BIT = (c * NUM_CLS + k) * NUM_GRP + g;
        assign hier_o[HIER_BIT] = |mirq_i[SRC_BASE +: GRP_SRC];
      end
    end
  end

endmodule

// File: rtl/ihs_core_lines.sv
module ihs_core_lines
  import ihs_pkg::*;
#(
  parameter int NUM_GRP = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_GRP-1:0] hier_ext_i,
  input  logic [NUM_GRP-1:0] hier_crit_i,
  input  logic [NUM_GRP-1:0] hier_mc_i,
  output logic               irq_ext_o,
  output logic               irq_crit_o,
  output logic               irq_mc_o,
  output top_cls_e           top_o
);

  logic     ext_d, crit_d, mc_d;
  logic     ext_q, crit_q, mc_q;
  top_cls_e top_d, top_q;
  logic     line_en, top_en;

  // Lines: one OR per class
  always_comb begin
    ext_d  = |hier_ext_i;
    crit_d = |hier_crit_i;
    mc_d   = |hier_mc_i;
  end

  // Priority code, encoded straight from the summary words
  always_comb begin
    top_d = TOP_NONE;
    if (hier_mc_i != '0) begin
      top_d = TOP_MC;
    end else if (hier_crit_i != '0) begin
      top_d = TOP_CRIT;
    end else if (hier_ext_i != '0) begin
      top_d = TOP_EXT;
    end
  end

  always_comb begin
    line_en = (ext_d != ext_q) || (crit_d != crit_q) || (mc_d != mc_q);
    top_en  = (top_d != top_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      crit_q <= 1'b0;
      mc_q   <= 1'b0;
    end else if (line_en) begin
      ext_q  <= ext_d;
      crit_q <= crit_d;
      mc_q   <= mc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= TOP_NONE;
    end else if (top_en) begin
      top_q <= top_d;
    end
  end

  assign irq_ext_o  = ext_q;
  assign irq_crit_o = crit_q;
  assign irq_mc_o   = mc_q;
  assign top_o      = top_q;

  // R5
  top_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_q |-> (top_q == TOP_MC));
  // R5
  top_crit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == TOP_CRIT) |-> (crit_q && !mc_q));
  // R5
  top_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == TOP_EXT) |-> (ext_q && !crit_q && !mc_q));
  // R5
  top_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (top_q == TOP_NONE) |-> (!ext_q && !crit_q && !mc_q));
  // R8
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!ext_q && !crit_q && !mc_q && top_q == TOP_NONE));

endmodule

// File: rtl/ihs_rd_port.sv
module ihs_rd_port
  import ihs_pkg::*;
#(
  parameter int NUM_GRP  = 32,
  parameter int NUM_CORE = 4,
  localparam int HW = NUM_CORE * NUM_CLS * NUM_GRP,
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [HW-1:0]      hier_i,
  input  logic [CW-1:0]      rd_core_i,
  input  logic [1:0]         rd_cls_i,
  output logic [NUM_GRP-1:0] rd_data_o
);

  logic [NUM_GRP-1:0] sel_d, data_q;
  logic               data_en;

  always_comb begin
    sel_d = '0;
    for (int c = 0; c < NUM_CORE; c++) begin
      for (int k = 0; k < NUM_CLS; k++) begin
        if (rd_core_i == CW'(c) && rd_cls_i == 2'(k)) begin
          sel_d = hier_i[(c * NUM_CLS + k) * NUM_GRP +: NUM_GRP];
        end
      end
    end
  end

  assign data_en = (sel_d != data_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= sel_d;
    end
  end

  assign rd_data_o = data_q;

  // R7
  rd_unused_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cls_i == 2'd3) |=> (rd_data_o == '0));
  // R8
  rd_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (data_q == '0));

endmodule

// File: rtl/irq_hier_sum.sv
module irq_hier_sum
  import ihs_pkg::*;
#(
  parameter int NUM_GRP  = 32,
  parameter int NUM_CORE = 4,
  parameter int GRP_SRC  = 32,
  localparam int MW = NUM_GRP * NUM_CORE * NUM_CLS * GRP_SRC,
  localparam int HW = NUM_CORE * NUM_CLS * NUM_GRP,
  localparam int CW = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MW-1:0]         mirq_i,
  input  logic [CW-1:0]         rd_core_i,
  input  logic [1:0]            rd_cls_i,
  output logic [NUM_GRP-1:0]    rd_data_o,
  output logic [NUM_CORE-1:0]   irq_ext_o,
  output logic [NUM_CORE-1:0]   irq_crit_o,
  output logic [NUM_CORE-1:0]   irq_mc_o,
  output logic [2*NUM_CORE-1:0] top_cls_o
);

  logic [HW-1:0] hier;

  ihs_hier_build #(
    .NUM_GRP (NUM_GRP),
    .NUM_CORE(NUM_CORE),
    .GRP_SRC (GRP_SRC)
  ) u_build (
    .mirq_i(mirq_i),
    .hier_o(hier)
  );

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    top_cls_e top_c;

    ihs_core_lines #(
      .NUM_GRP(NUM_GRP)
    ) u_lines (
      .clk        (clk),
      .rst_n      (rst_n),
      .hier_ext_i (hier[(c * NUM_CLS + CLS_EXT)  * NUM_GRP +: NUM_GRP]),
      .hier_crit_i(hier[(c * NUM_CLS + CLS_CRIT) * NUM_GRP +: NUM_GRP]),
      .hier_mc_i  (hier[(c * NUM_CLS + CLS_MC)   * NUM_GRP +: NUM_GRP]),
      .irq_ext_o  (irq_ext_o[c]),
      .irq_crit_o (irq_crit_o[c]),
      .irq_mc_o   (irq_mc_o[c]),
      .top_o      (top_c)
    );

    assign top_cls_o[2*c +: 2] = top_c;

    // R1 R4: read word of machine check for this core agrees with its line
    rd_mc_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_core_i == CW'(c) && rd_cls_i == 2'(CLS_MC)) |=> ((|rd_data_o) == irq_mc_o[c]));
    // R1 R4: read word of non-critical for this core agrees with its line
    rd_ext_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_core_i == CW'(c) && rd_cls_i == 2'(CLS_EXT)) |=> ((|rd_data_o) == irq_ext_o[c]));
  end

  ihs_rd_port #(
    .NUM_GRP (NUM_GRP),
    .NUM_CORE(NUM_CORE)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .hier_i   (hier),
    .rd_core_i(rd_core_i),
    .rd_cls_i (rd_cls_i),
    .rd_data_o(rd_data_o)
  );

endmodule

// File: tb/irq_hier_sum_tb.sv
`timescale 1ns/100ps
module irq_hier_sum_tb;

  localparam int NG = 32;
  localparam int NC = 4;
  localparam int NS = 32;
  localparam int MW = NG * NC * 3 * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [MW-1:0] mirq = '0;
  logic [1:0]    rd_core = '0;
  logic [1:0]    rd_cls = '0;
  logic [NG-1:0] rd_data;
  logic [NC-1:0] irq_ext, irq_crit, irq_mc;
  logic [2*NC-1:0] top_cls;

  int n_chk = 0;
  int n_err = 0;
  bit armed = 0;
  string phase = "R8";

  logic [NG-1:0] exp_rd;
  logic [NC-1:0] exp_ext, exp_crit, exp_mc;
  logic [2*NC-1:0] exp_top;

  irq_hier_sum #(.NUM_GRP(NG), .NUM_CORE(NC), .GRP_SRC(NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .mirq_i(mirq), .rd_core_i(rd_core), .rd_cls_i(rd_cls),
    .rd_data_o(rd_data), .irq_ext_o(irq_ext), .irq_crit_o(irq_crit),
    .irq_mc_o(irq_mc), .top_cls_o(top_cls)
  );

  always #2.5 clk = ~clk;

  function automatic int base(int c, int k, int g);
    return ((g * NC + c) * 3 + k) * NS;
  endfunction

  function automatic logic [NG-1:0] word(int c, int k);
    logic [NG-1:0] w = '0;
    if (k > 2) return '0;
    for (int g = 0; g < NG; g++) w[g] = (mirq[base(c, k, g) +: NS] != '0);
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s (%s) act=%h exp=%h at %0t", tag, phase, act, exp, $time);
    end
  endtask

  // Reference model: values captured at each rising edge are due after it
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_rd = '0; exp_ext = '0; exp_crit = '0; exp_mc = '0; exp_top = '0;
    end else begin
      exp_rd = word(int'(rd_core), int'(rd_cls));
      for (int c = 0; c < NC; c++) begin
        exp_ext[c]  = word(c, 0) != '0;
        exp_crit[c] = word(c, 1) != '0;
        exp_mc[c]   = word(c, 2) != '0;
        exp_top[2*c +: 2] = exp_mc[c] ? 2'b11 : exp_crit[c] ? 2'b10 : exp_ext[c] ? 2'b01 : 2'b00;
      end
    end
    armed = 1;
  end

  always @(negedge clk) begin
    if (armed) begin
      chk(rd_data == exp_rd, "R1 rd_data", rd_data, exp_rd);
      chk(irq_ext == exp_ext, "R4 irq_ext", 32'(irq_ext), 32'(exp_ext));
      chk(irq_crit == exp_crit, "R4 irq_crit", 32'(irq_crit), 32'(exp_crit));
      chk(irq_mc == exp_mc, "R4 irq_mc", 32'(irq_mc), 32'(exp_mc));
      chk(top_cls == exp_top, "R5 top_cls", 32'(top_cls), 32'(exp_top));
    end
  end

  task automatic after_edge();
    @(posedge clk); #1;
  endtask

  // Wait for the registered outputs, then sample at the falling edge
  task automatic settle();
    @(posedge clk); @(negedge clk); #0.5;
  endtask

  task automatic rd_check(input int c, input int k, input logic [31:0] exp, input string tag);
    rd_core = 2'(c); rd_cls = 2'(k);
    settle();
    chk(rd_data == exp, tag, rd_data, exp);
    after_edge();
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); #0.5;
    // R8: reset state
    chk(irq_ext == '0 && irq_crit == '0 && irq_mc == '0, "R8 lines", 32'({irq_ext, irq_crit, irq_mc}), 0);
    chk(top_cls == '0 && rd_data == '0, "R8 code/read", 32'(top_cls) | rd_data, 0);
    mirq[base(1, 2, 4)] = 1'b1;
    settle();
    chk(irq_mc == '0, "R8 held", 32'(irq_mc), 0);
    mirq = '0;
    rst_n = 1'b1;
    after_edge();

    phase = "R2";
    mirq[base(1, 1, 31) + 31] = 1'b1;
    mirq[base(2, 2, 0)] = 1'b1;
    after_edge();
    rd_check(1, 1, 32'h8000_0000, "R2 grp31");
    rd_check(2, 2, 32'h0000_0001, "R2 grp0");
    mirq = '0;
    after_edge();

    phase = "R3";
    for (int c = 0; c < NC; c++) mirq[base(c, 0, 7) + 5] = 1'b1;
    settle();
    chk(irq_ext == 4'hF, "R3 all lines", 32'(irq_ext), 32'hF);
    after_edge();
    for (int c = 0; c < NC; c++) rd_check(c, 0, 32'h80, "R3 each core");

    phase = "R6";
    mirq = '0;
    settle();
    chk(irq_ext == '0, "R6 lines drop", 32'(irq_ext), 0);
    chk(rd_data == '0, "R6 read drops", rd_data, 0);
    after_edge();

    phase = "R5";
    mirq[base(0, 0, 3)] = 1'b1;
    settle(); chk(top_cls[1:0] == 2'b01, "R5 ext", 32'(top_cls[1:0]), 1); after_edge();
    mirq[base(0, 1, 9) + 2] = 1'b1;
    settle(); chk(top_cls[1:0] == 2'b10, "R5 crit", 32'(top_cls[1:0]), 2); after_edge();
    mirq[base(0, 2, 20) + 17] = 1'b1;
    settle(); chk(top_cls[1:0] == 2'b11, "R5 mc", 32'(top_cls[1:0]), 3); after_edge();
    mirq[base(0, 2, 20) + 17] = 1'b0;
    settle(); chk(top_cls[1:0] == 2'b10, "R5 mc gone", 32'(top_cls[1:0]), 2); after_edge();

    phase = "R7";
    rd_check(0, 3, 32'h0, "R7 unused class");

    phase = "R9";
    mirq = '0;
    mirq[base(3, 2, 12) + 8] = 1'b1;
    settle();
    chk(irq_mc == 4'h8 && irq_ext == '0 && irq_crit == '0, "R9 lines", 32'({irq_ext, irq_crit, irq_mc}), 32'h8);
    chk(top_cls == 8'hC0, "R9 codes", 32'(top_cls), 32'hC0);
    after_edge();
    rd_check(2, 2, 32'h0, "R9 other core word");
    rd_check(3, 2, 32'h1000, "R9 own word");

    phase = "R1 random";
    mirq = '0;
    for (int i = 0; i < 600; i++) begin
      if (i % 24 == 0) mirq = '0;
      for (int j = 0; j < 2; j++) mirq[$urandom_range(MW - 1)] ^= 1'b1;
      if (i % 5 == 0) begin
        int c = $urandom_range(NC - 1);
        int g = $urandom_range(NG - 1);
        for (int s = 0; s < NS; s++) mirq[base(c, $urandom_range(2), g) + s] = 1'b0;
      end
      rd_core = 2'($urandom_range(3));
      rd_cls  = 2'($urandom_range(3));
      after_edge();
    end
    settle();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule